// File: doc/BRIEF.md
# Parallel-Mode Flash Page Programming Sequencer

This block sits on the programmer side of a parallel programming link to an 8-bit microcontroller. After a start request it erases the device. It then loads the write-flash command and fills one flash page with 16-bit words taken from a valid/ready stream. Last, it commits the page with a write pulse. All device pins come from registers: the two-bit mode select, the byte select, the 8-bit data bus, the positive load strobe, the positive page-latch strobe and the active-low write strobe. The block also watches the device's ready/busy line.

Each pin operation is one "step". The select and data values are placed on the pins one cycle before the strobe. They stay unchanged for the whole strobe, which lasts a set number of cycles. They are still unchanged in the cycle after the strobe ends. The upper bits of the low address byte come from a page-select input. The low bits come from the index of the word within the page. After the erase pulse and again after the commit pulse, the sequencer waits for ready/busy to read high before it goes on. When the device is ready after the commit, the sequencer raises a done flag. The flag stays high until the next start.

Top module: `flash_page_seq`

## Requirements
- R1: After reset, the load and latch strobes are low, the write strobe is high, and busy, done and word-ready are all low.
- R2: A start request accepted while idle first gives one load strobe with mode 2'b10, byte select 0 and data 8'h80. One write-strobe low pulse follows, and the mode, byte select and data keep those same values during that pulse.
- R3: No load strobe rises while ready/busy is low. After each write pulse, the next step waits until ready/busy is high.
- R4: After the erase completes, the next step is a load with mode 2'b10, byte select 0 and data 8'h10.
- R5: Each word i gives, in this order: a load with mode 2'b00, byte select 0 and data {pageSel, i}; a load with mode 2'b01, byte select 0 and the word's bits 7:0; a load with mode 2'b01, byte select 1 and the word's bits 15:8; then a latch strobe with mode 2'b01, byte select 1 and the bits 15:8 still on the bus.
- R6: Word-ready is high only while the sequencer is waiting for a word. Each cycle with both valid and ready high takes exactly one word. Exactly PAGE_WORDS words are taken per run, with i counting from 0.
- R7: After the latch of the last word comes one write-strobe low pulse, with the pins left at the latch values. Done rises only once ready/busy is high, busy falls at the same time, and done stays high until the next accepted start.
- R8: The mode, byte select and data outputs are stable in the cycle before any strobe becomes active, in every cycle it is active, and in the cycle after it ends.
- R9: Every load, latch and write strobe is active for exactly STROBE_W consecutive cycles.
- R10: A start request while busy is ignored. The current run goes on with no second erase.
- R11: At most one of the three strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start an erase-and-program run (taken only while idle) |
| pageSel | input | 8-log2(PAGE_WORDS) | Upper bits of the low address byte |
| wordValid | input | 1 | Word stream valid |
| wordData | input | 16 | Word to program |
| wordReady | output | 1 | Sequencer accepts a word |
| rdyBsy | input | 1 | Device ready (high) / busy (low) |
| progMode | output | 2 | Mode select pins (load-address 00, load-data 01, load-command 10) |
| byteSel | output | 1 | Byte select pin |
| pinData | output | 8 | Device data bus |
| ldStrobe | output | 1 | Positive load pulse |
| latchStrobe | output | 1 | Positive page-latch pulse |
| wrStrobeN | output | 1 | Active-low write pulse |
| seqBusy | output | 1 | Run in progress |
| seqDone | output | 1 | Page committed and device ready |

## Verification
The embedded assertions check pin timing on every cycle. Select and data must not move in the cycle before a strobe, while it is active, or in the cycle after it. They also check that only one strobe is active at a time, that word-ready is high only between steps, and that done never rises unless ready/busy was high. Other properties need whole runs: the order of the steps, the exact command and address byte values, the strobe width, the wait for ready/busy, and ignoring a start that arrives mid-run. The bench shows these by logging every strobe event and comparing the log with a list it builds from the requirements. It runs this for random pages, data, busy times and stream gaps.

// File: rtl/flash_page_seq_pkg.sv
package flash_page_seq_pkg;

  typedef enum logic [2:0] {
    STEP_ERASE = 3'd0,
    STEP_PGCMD = 3'd1,
    STEP_ADDR  = 3'd2,
    STEP_DLO   = 3'd3,
    STEP_DHI   = 3'd4,
    STEP_LATCH = 3'd5,
    STEP_WRITE = 3'd6
  } stepKind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  typedef struct packed {
    logic      startStep;
    stepKind_e stepKind;
    logic      capWord;
    logic      clrIdx;
    logic      incIdx;
  } ctrlStrobes_t;

  localparam logic [1:0] MODE_ADDR = 2'b00;
  localparam logic [1:0] MODE_DATA = 2'b01;
  localparam logic [1:0] MODE_CMD  = 2'b10;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_WRFLASH = 8'h10;

endpackage

// File: rtl/flash_page_seq_dp.sv
module flash_page_seq_dp
  import flash_page_seq_pkg::*;
#(
  parameter int PAGE_WORDS = 8,
  parameter int STROBE_W   = 3,
  parameter int IDX_W      = $clog2(PAGE_WORDS),
  parameter int SEL_W      = 8 - IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     ctl,
  input  logic [SEL_W-1:0] pageSel,
  input  logic [15:0]      wordData,
  output logic             phaseIdle,
  output logic             stepDone,
  output logic             lastWord,
  output logic [1:0]       progMode,
  output logic             byteSel,
  output logic [7:0]       pinData,
  output logic             ldStrobe,
  output logic             latchStrobe,
  output logic             wrStrobeN
);

  localparam int CNT_W = (STROBE_W > 1) ? $clog2(STROBE_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAGE_WORDS - 1);

  phase_e           phase;
  stepKind_e        kindReg;
  logic [CNT_W-1:0] pulseCnt;
  logic [15:0]      wordReg;
  logic [IDX_W-1:0] wordIdx;

  logic [1:0] nextMode;
  logic       nextBs;
  logic [7:0] nextData;

  assign phaseIdle = (phase == PH_IDLE);
  assign stepDone  = (phase == PH_HOLD);
  assign lastWord  = (wordIdx == IDX_LAST);

  always_comb begin
    nextMode = progMode;
    nextBs   = byteSel;
    nextData = pinData;
    unique case (ctl.stepKind)
      STEP_ERASE: begin nextMode = MODE_CMD;  nextBs = 1'b0; nextData = CMD_ERASE; end
      STEP_PGCMD: begin nextMode = MODE_CMD;  nextBs = 1'b0; nextData = CMD_WRFLASH; end
      STEP_ADDR:  begin nextMode = MODE_ADDR; nextBs = 1'b0; nextData = {pageSel, wordIdx}; end
      STEP_DLO:   begin nextMode = MODE_DATA; nextBs = 1'b0; nextData = wordReg[7:0]; end
      STEP_DHI:   begin nextMode = MODE_DATA; nextBs = 1'b1; nextData = wordReg[15:8]; end
      STEP_LATCH: begin nextMode = MODE_DATA; nextBs = 1'b1; nextData = wordReg[15:8]; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg <= '0;
      wordIdx <= '0;
    end else begin
      if (ctl.capWord) wordReg <= wordData;
      if (ctl.clrIdx) wordIdx <= '0;
      else if (ctl.incIdx) wordIdx <= wordIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      kindReg     <= STEP_ERASE;
      pulseCnt    <= '0;
      progMode    <= MODE_ADDR;
      byteSel     <= 1'b0;
      pinData     <= '0;
      ldStrobe    <= 1'b0;
      latchStrobe <= 1'b0;
      wrStrobeN   <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (ctl.startStep) begin
            kindReg  <= ctl.stepKind;
            progMode <= nextMode;
            byteSel  <= nextBs;
            pinData  <= nextData;
            phase    <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          pulseCnt <= '0;
          phase    <= PH_PULSE;
          if (kindReg == STEP_WRITE)      wrStrobeN   <= 1'b0;
          else if (kindReg == STEP_LATCH) latchStrobe <= 1'b1;
          else                            ldStrobe    <= 1'b1;
        end
        PH_PULSE: begin
          if (pulseCnt == CNT_LAST) begin
            ldStrobe    <= 1'b0;
            latchStrobe <= 1'b0;
            wrStrobeN   <= 1'b1;
            phase       <= PH_HOLD;
          end else begin
            pulseCnt <= pulseCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R8
  setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ldStrobe) || $rose(latchStrobe) || $fell(wrStrobeN)) |->
      $stable({progMode, byteSel, pinData}));

  // R8
  active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldStrobe || latchStrobe || !wrStrobeN) |-> $stable({progMode, byteSel, pinData}));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ldStrobe) || $fell(latchStrobe) || $rose(wrStrobeN)) |->
      $stable({progMode, byteSel, pinData}));

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ldStrobe, latchStrobe, !wrStrobeN}));

endmodule

// File: rtl/flash_page_seq_ctrl.sv
module flash_page_seq_ctrl
  import flash_page_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         wordValid,
  input  logic         rdyBsy,
  input  logic         phaseIdle,
  input  logic         stepDone,
  input  logic         lastWord,
  output ctrlStrobes_t ctl,
  output logic         wordReady,
  output logic         seqBusy,
  output logic         seqDone
);

  typedef enum logic [3:0] {
    S_IDLE, S_ER_CMD, S_ER_WR, S_ER_WAIT, S_PG_CMD, S_WORD_WAIT,
    S_ADDR, S_DLO, S_DHI, S_LATCH, S_PG_WR, S_PG_WAIT
  } state_e;

  state_e state;
  logic   stepState;

  assign wordReady = (state == S_WORD_WAIT);
  assign seqBusy   = (state != S_IDLE);

  always_comb begin
    stepState    = 1'b1;
    ctl.stepKind = STEP_ERASE;
    unique case (state)
      S_ER_CMD: ctl.stepKind = STEP_ERASE;
      S_ER_WR:  ctl.stepKind = STEP_WRITE;
      S_PG_CMD: ctl.stepKind = STEP_PGCMD;
      S_ADDR:   ctl.stepKind = STEP_ADDR;
      S_DLO:    ctl.stepKind = STEP_DLO;
      S_DHI:    ctl.stepKind = STEP_DHI;
      S_LATCH:  ctl.stepKind = STEP_LATCH;
      S_PG_WR:  ctl.stepKind = STEP_WRITE;
      default:  stepState = 1'b0;
    endcase
    ctl.startStep = stepState && phaseIdle;
    ctl.capWord   = wordReady && wordValid;
    ctl.clrIdx    = (state == S_IDLE) && startReq;
    ctl.incIdx    = (state == S_LATCH) && stepDone && !lastWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      seqDone <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE:      if (startReq) begin state <= S_ER_CMD; seqDone <= 1'b0; end
        S_ER_CMD:    if (stepDone) state <= S_ER_WR;
        S_ER_WR:     if (stepDone) state <= S_ER_WAIT;
        S_ER_WAIT:   if (rdyBsy) state <= S_PG_CMD;
        S_PG_CMD:    if (stepDone) state <= S_WORD_WAIT;
        S_WORD_WAIT: if (wordValid) state <= S_ADDR;
        S_ADDR:      if (stepDone) state <= S_DLO;
        S_DLO:       if (stepDone) state <= S_DHI;
        S_DHI:       if (stepDone) state <= S_LATCH;
        S_LATCH:     if (stepDone) state <= lastWord ? S_PG_WR : S_WORD_WAIT;
        S_PG_WR:     if (stepDone) state <= S_PG_WAIT;
        S_PG_WAIT:   if (rdyBsy) begin state <= S_IDLE; seqDone <= 1'b1; end
        default:     state <= S_IDLE;
      endcase
    end
  end

  // R6
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> phaseIdle);

  // R6
  one_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordReady) |=> !wordReady);

  // R7
  done_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqDone) |-> $past(rdyBsy));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !seqBusy);

endmodule

// File: rtl/flash_page_seq.sv
module flash_page_seq
  import flash_page_seq_pkg::*;
#(
  parameter int PAGE_WORDS = 8,
  parameter int STROBE_W   = 3,
  localparam int IDX_W     = $clog2(PAGE_WORDS),
  localparam int SEL_W     = 8 - IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [SEL_W-1:0] pageSel,
  input  logic             wordValid,
  input  logic [15:0]      wordData,
  output logic             wordReady,
  input  logic             rdyBsy,
  output logic [1:0]       progMode,
  output logic             byteSel,
  output logic [7:0]       pinData,
  output logic             ldStrobe,
  output logic             latchStrobe,
  output logic             wrStrobeN,
  output logic             seqBusy,
  output logic             seqDone
);

  ctrlStrobes_t ctl;
  logic phaseIdle, stepDone, lastWord;

  flash_page_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordValid(wordValid),
    .rdyBsy(rdyBsy), .phaseIdle(phaseIdle), .stepDone(stepDone),
    .lastWord(lastWord), .ctl(ctl), .wordReady(wordReady),
    .seqBusy(seqBusy), .seqDone(seqDone)
  );

  flash_page_seq_dp #(
    .PAGE_WORDS(PAGE_WORDS), .STROBE_W(STROBE_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pageSel(pageSel), .wordData(wordData),
    .phaseIdle(phaseIdle), .stepDone(stepDone), .lastWord(lastWord),
    .progMode(progMode), .byteSel(byteSel), .pinData(pinData),
    .ldStrobe(ldStrobe), .latchStrobe(latchStrobe), .wrStrobeN(wrStrobeN)
  );

  // R3
  load_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && !rdyBsy && !wrStrobeN) |=> !ldStrobe);

endmodule

// File: tb/flash_page_seq_tb_top.sv
module flash_page_seq_tb_top;

  localparam int PW    = 8;
  localparam int SW    = 3;
  localparam int IDX_W = $clog2(PW);
  localparam int SEL_W = 8 - IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [SEL_W-1:0] pageSel = '0;
  logic wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic wordReady;
  logic rdyBsy = 1'b1;
  logic [1:0] progMode;
  logic byteSel;
  logic [7:0] pinData;
  logic ldStrobe, latchStrobe, wrStrobeN, seqBusy, seqDone;

  always #2.5 clk = ~clk;

  flash_page_seq #(.PAGE_WORDS(PW), .STROBE_W(SW)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pageSel(pageSel),
    .wordValid(wordValid), .wordData(wordData), .wordReady(wordReady),
    .rdyBsy(rdyBsy), .progMode(progMode), .byteSel(byteSel), .pinData(pinData),
    .ldStrobe(ldStrobe), .latchStrobe(latchStrobe), .wrStrobeN(wrStrobeN),
    .seqBusy(seqBusy), .seqDone(seqDone)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Device model: busy while write strobe low and busyLen cycles after.
  int busyLen = 4;
  int busyCnt = 0;
  always @(negedge clk) begin
    if (!wrStrobeN) begin
      rdyBsy <= 1'b0;
      busyCnt = busyLen;
    end else if (busyCnt > 0) begin
      busyCnt--;
    end else begin
      rdyBsy <= 1'b1;
    end
  end

  // Event log: {kind[1:0], mode[1:0], bs, data[7:0]}; kind 1 load, 2 latch, 3 write
  logic [12:0] logEv [0:63];
  int logCnt = 0;
  logic [12:0] expEv [0:63];
  int expCnt = 0;
  bit monOn = 0;
  logic prevLd = 0, prevLatch = 0, prevWrN = 1;
  logic [10:0] prevPins = '0;
  int widthCnt = 0;

  function automatic logic [12:0] mkEv(input logic [1:0] k, input logic [1:0] m,
                                       input logic b, input logic [7:0] d);
    return {k, m, b, d};
  endfunction

  always @(negedge clk) begin
    logic [10:0] pins;
    bit act, prevAct;
    pins = {progMode, byteSel, pinData};
    act = ldStrobe || latchStrobe || !wrStrobeN;
    prevAct = prevLd || prevLatch || !prevWrN;
    if (monOn) begin
      // R11
      check($countones({ldStrobe, latchStrobe, !wrStrobeN}) <= 1, "R11",
            "strobes active", {ldStrobe, latchStrobe, !wrStrobeN}, 0);
      if (act && !prevAct) begin
        check(pins == prevPins, "R8", "setup pins", pins, prevPins);
        if (ldStrobe) check(rdyBsy == 1'b1, "R3", "load while busy", rdyBsy, 1);
        if (logCnt < 64)
          logEv[logCnt] = {ldStrobe ? 2'd1 : latchStrobe ? 2'd2 : 2'd3, pins};
        logCnt++;
        widthCnt = 1;
      end else if (act && prevAct) begin
        check(pins == prevPins, "R8", "pins during strobe", pins, prevPins);
        widthCnt++;
      end else if (!act && prevAct) begin
        check(widthCnt == SW, "R9", "strobe width", widthCnt, SW);
        check(pins == prevPins, "R8", "hold pins", pins, prevPins);
      end
      if (wordReady) check(!act, "R6", "ready during step", act, 0);
    end
    prevLd = ldStrobe; prevLatch = latchStrobe; prevWrN = wrStrobeN;
    prevPins = pins;
  end

  logic [15:0] words [0:PW-1];

  task automatic buildExp(input logic [SEL_W-1:0] sel);
    expCnt = 0;
    expEv[expCnt++] = mkEv(2'd1, 2'b10, 1'b0, 8'h80);
    expEv[expCnt++] = mkEv(2'd3, 2'b10, 1'b0, 8'h80);
    expEv[expCnt++] = mkEv(2'd1, 2'b10, 1'b0, 8'h10);
    for (int i = 0; i < PW; i++) begin
      expEv[expCnt++] = mkEv(2'd1, 2'b00, 1'b0, {sel, IDX_W'(i)});
      expEv[expCnt++] = mkEv(2'd1, 2'b01, 1'b0, words[i][7:0]);
      expEv[expCnt++] = mkEv(2'd1, 2'b01, 1'b1, words[i][15:8]);
      expEv[expCnt++] = mkEv(2'd2, 2'b01, 1'b1, words[i][15:8]);
    end
    expEv[expCnt++] = mkEv(2'd3, 2'b01, 1'b1, words[PW-1][15:8]);
  endtask

  task automatic runPage(input logic [SEL_W-1:0] sel, input int bLen,
                         input int maxGap, input bit pokeStart);
    int taken;
    int guard;
    busyLen = bLen;
    for (int i = 0; i < PW; i++) words[i] = 16'($urandom);
    buildExp(sel);
    logCnt = 0;
    pageSel = sel;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(seqDone == 1'b0 && seqBusy == 1'b1, "R7", "done cleared by start",
          {seqDone, seqBusy}, 2'b01);
    taken = 0;
    guard = 0;
    while (taken < PW && guard < 20000) begin
      if (!wordValid) begin
        for (int g = $urandom_range(maxGap, 0); g > 0; g--) @(negedge clk);
        wordValid = 1'b1;
        wordData = words[taken];
      end
      if (pokeStart && taken == 2) startReq = 1'b1;
      if (wordReady) begin
        @(negedge clk);
        startReq = 1'b0;
        taken++;
        wordValid = 1'b0;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    startReq = 1'b0;
    wordValid = 1'b0;
    check(taken == PW, "R6", "words taken", taken, PW);
    repeat (3) @(negedge clk);
    check(wordReady == 1'b0, "R6", "ready after full page", wordReady, 0);
    guard = 0;
    while (!seqDone && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (!seqDone) check(seqBusy == 1'b1, "R7", "busy before done", seqBusy, 1);
    end
    check(seqDone == 1'b1, "R7", "done raised", seqDone, 1);
    check(rdyBsy == 1'b1, "R7", "ready at done", rdyBsy, 1);
    check(seqBusy == 1'b0, "R7", "busy low at done", seqBusy, 0);
    check(logCnt == expCnt, pokeStart ? "R10" : "R5", "event count", logCnt, expCnt);
    for (int i = 0; i < expCnt && i < logCnt; i++) begin
      string rq;
      rq = (i < 2) ? "R2" : (i == 2) ? "R4" : (i == expCnt - 1) ? "R7" : "R5";
      check(logEv[i] == expEv[i], rq, $sformatf("event %0d", i), logEv[i], expEv[i]);
    end
    repeat (5) @(negedge clk);
    check(seqDone == 1'b1, "R7", "done held", seqDone, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(ldStrobe == 0 && latchStrobe == 0 && wrStrobeN == 1, "R1", "reset strobes",
          {ldStrobe, latchStrobe, wrStrobeN}, 3'b001);
    check(seqBusy == 0 && seqDone == 0 && wordReady == 0, "R1", "reset flags",
          {seqBusy, seqDone, wordReady}, 0);
    monOn = 1;
    runPage(SEL_W'(0), 4, 0, 1'b0);
    runPage('1, 0, 3, 1'b0);
    runPage(SEL_W'($urandom), 12, 2, 1'b1);
    for (int r = 0; r < 3; r++)
      runPage(SEL_W'($urandom), $urandom_range(20, 1), $urandom_range(4, 0), 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule